// File: doc/BRIEF.md
# Single-Item Coin Vending Controller

This block is the control state machine of a vending machine that sells a single item priced at 15 cents. It accepts two coin values, 5 and 10 cents, each reported on its own one-cycle pulse input. It keeps the running credit and acts on two customer buttons: one asks for the item, the other asks for the money back. The credit can be 0, 5, 10, 15 or 20 cents. A dime inserted at 10 cents takes the credit to 20. At 15 cents or more, any further coin is handed straight back.

All four outputs are one-cycle pulses: drop the item, and return 5, 10 or 15 cents. Each pulse comes from a flip-flop, so the outputs cannot glitch. An output reacts in the clock cycle after the input that caused it. When several inputs arrive in the same cycle, one of them is chosen by a fixed priority and the others are dropped. Any unused credit encoding falls back to zero credit on the next edge.

Top module: `vend_ctrl`

## Requirements
- R1: After reset the credit is 0 and all four output pulses are low.
- R2: A nickel pulse at credit 0, 5 or 10 adds 5 cents to the credit and raises no output.
- R3: A dime pulse at credit 0, 5 or 10 adds 10 cents to the credit and raises no output, so 10 becomes 20.
- R4: A coin at credit 15 or 20 leaves the credit unchanged. A nickel is handed back on the 5-cent output and a dime on the 10-cent output.
- R5: An item request at credit 15 or 20 pulses drop, clears the credit, and also pulses the 5-cent return when the credit was 20.
- R6: An item request at credit 0, 5 or 10 raises no output and leaves the credit unchanged.
- R7: A refund request clears the credit and pulses the matching return output for 5, 10 or 15 cents. At 20 cents it pulses the 5-cent and 15-cent returns together.
- R8: A refund request at credit 0 raises no output and leaves the credit at 0.
- R9: When several inputs are high in the same cycle, only the highest-priority one acts: refund first, then item request, then dime, then nickel.
- R10: Every output is registered. It is high only in the cycle right after the triggering input, and it is low in any cycle that follows an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was inserted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was inserted |
| vend_req_i | input | 1 | One-cycle pulse: the customer asks for the item |
| refund_req_i | input | 1 | One-cycle pulse: the customer asks for the credit back |
| drop_o | output | 1 | One-cycle pulse: release the item |
| ret5_o | output | 1 | One-cycle pulse: hand back 5 cents |
| ret10_o | output | 1 | One-cycle pulse: hand back 10 cents |
| ret15_o | output | 1 | One-cycle pulse: hand back 15 cents |

## Verification
The assertions take two things for granted. First, inputs change only away from the rising edge. Second, every input is held low while reset is asserted, so the first sampled cycle starts from zero credit with no pending command.

The stimulus stays within these limits. It drives the inputs on the falling edge and keeps them low until reset has been released. It then reaches each of the five credit levels using legal coin sequences. From each level it applies all sixteen input combinations, which covers the overlaps that the priority rule resolves. After every step it reads the remaining credit back with a refund, whose return pattern identifies each level uniquely.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int CREDIT_W = 3;

  typedef enum logic [CREDIT_W-1:0] {
    CR_0  = 3'd0,
    CR_5  = 3'd1,
    CR_10 = 3'd2,
    CR_15 = 3'd3,
    CR_20 = 3'd4
  } credit_e;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_REFUND = 3'd1,
    CMD_VEND   = 3'd2,
    CMD_DIME   = 3'd3,
    CMD_NICKEL = 3'd4
  } cmd_e;

  typedef struct packed {
    logic drop;
    logic ret5;
    logic ret10;
    logic ret15;
  } pulse_t;

  localparam int PULSE_W = $bits(pulse_t);

endpackage

// File: rtl/vend_pri.sv
module vend_pri
  import vend_pkg::*;
(
  input  logic nickel_i,
  input  logic dime_i,
  input  logic vend_req_i,
  input  logic refund_req_i,
  output cmd_e cmd_o
);

  // Fixed order: refund, item request, dime, nickel.
  always_comb begin
    if (refund_req_i)    cmd_o = CMD_REFUND;
    else if (vend_req_i) cmd_o = CMD_VEND;
    else if (dime_i)     cmd_o = CMD_DIME;
    else if (nickel_i)   cmd_o = CMD_NICKEL;
    else                 cmd_o = CMD_NONE;
  end

endmodule

// File: rtl/vend_step.sv
module vend_step
  import vend_pkg::*;
(
  input  logic [CREDIT_W-1:0] cur_i,
  input  cmd_e                cmd_i,
  output logic [CREDIT_W-1:0] nxt_o,
  output logic                upd_o,
  output pulse_t              pls_o
);

  logic full;
  logic legal;

  always_comb begin
    legal = 1'b1;
    full  = 1'b0;
    case (cur_i)
      CR_0, CR_5, CR_10: full = 1'b0;
      CR_15, CR_20:      full = 1'b1;
      default:           legal = 1'b0;
    endcase
  end

  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b0;
    pls_o = '0;
    if (!legal) begin
      // Unused encodings fall back to zero credit with no pulses.
      nxt_o = CR_0;
      upd_o = 1'b1;
    end else begin
      case (cmd_i)
        CMD_REFUND: begin
          nxt_o = CR_0;
          upd_o = 1'b1;
          case (cur_i)
            CR_5:    pls_o.ret5  = 1'b1;
            CR_10:   pls_o.ret10 = 1'b1;
            CR_15:   pls_o.ret15 = 1'b1;
            CR_20: begin
              pls_o.ret5  = 1'b1;
              pls_o.ret15 = 1'b1;
            end
            default: pls_o = '0;
          endcase
        end
        CMD_VEND: begin
          if (full) begin
            nxt_o      = CR_0;
            upd_o      = 1'b1;
            pls_o.drop = 1'b1;
            pls_o.ret5 = (cur_i == CR_20);
          end
        end
        CMD_DIME: begin
          if (full) begin
            pls_o.ret10 = 1'b1;
          end else begin
            upd_o = 1'b1;
            nxt_o = cur_i + CREDIT_W'(2);
          end
        end
        CMD_NICKEL: begin
          if (full) begin
            pls_o.ret5 = 1'b1;
          end else begin
            upd_o = 1'b1;
            nxt_o = cur_i + CREDIT_W'(1);
          end
        end
        default: begin
          nxt_o = cur_i;
          upd_o = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nickel_i,
  input  logic dime_i,
  input  logic vend_req_i,
  input  logic refund_req_i,
  output logic drop_o,
  output logic ret5_o,
  output logic ret10_o,
  output logic ret15_o
);

  cmd_e                cmd;
  logic [CREDIT_W-1:0] credit_q;
  logic [CREDIT_W-1:0] credit_d;
  logic                credit_en;
  pulse_t              pls_d;
  logic [PULSE_W-1:0]  pls_q;

  vend_pri u_pri (
    .nickel_i     (nickel_i),
    .dime_i       (dime_i),
    .vend_req_i   (vend_req_i),
    .refund_req_i (refund_req_i),
    .cmd_o        (cmd)
  );

  vend_step u_step (
    .cur_i (credit_q),
    .cmd_i (cmd),
    .nxt_o (credit_d),
    .upd_o (credit_en),
    .pls_o (pls_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= CR_0;
    end else if (credit_en) begin
      credit_q <= credit_d;
    end
  end

  // One flop per output pulse.
  for (genvar gi = 0; gi < PULSE_W; gi++) begin : g_pls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pls_q[gi] <= 1'b0;
      else        pls_q[gi] <= pls_d[gi];
    end
  end

  assign {drop_o, ret5_o, ret10_o, ret15_o} = pls_q;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nickel_i,
  input logic       dime_i,
  input logic       vend_req_i,
  input logic       refund_req_i,
  input logic       drop_o,
  input logic       ret5_o,
  input logic       ret10_o,
  input logic       ret15_o,
  input logic [2:0] credit_q
);

  a_r7_refund_clears: assert property (@(posedge clk) disable iff (!rst_n)
    refund_req_i |=> credit_q == 3'd0);

  a_r8_refund_at_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (refund_req_i && credit_q == 3'd0) |=> !(drop_o || ret5_o || ret10_o || ret15_o));

  a_r5_drop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(vend_req_i && !refund_req_i));

  a_r5_drop_no_big_return: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> !(ret10_o || ret15_o));

  a_r6_short_request_keeps_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (vend_req_i && !refund_req_i && credit_q < 3'd3) |=> credit_q == $past(credit_q));

  a_r7_ret15_only_from_refund: assert property (@(posedge clk) disable iff (!rst_n)
    ret15_o |-> $past(refund_req_i));

  a_r10_drop_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> !drop_o);

  a_r10_idle_gives_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(nickel_i || dime_i || vend_req_i || refund_req_i) |=> !(drop_o || ret5_o || ret10_o || ret15_o));

  a_r4_credit_range: assert property (@(posedge clk) disable iff (!rst_n)
    $past(credit_q) <= 3'd4 |-> credit_q <= 3'd4);

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (.*);

// File: tb/vend_ctrl_tb.sv
`timescale 1ns/1ps
module vend_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nickel_i = 1'b0, dime_i = 1'b0, vend_req_i = 1'b0, refund_req_i = 1'b0;
  logic drop_o, ret5_o, ret10_o, ret15_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vend_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .nickel_i     (nickel_i),
    .dime_i       (dime_i),
    .vend_req_i   (vend_req_i),
    .refund_req_i (refund_req_i),
    .drop_o       (drop_o),
    .ret5_o       (ret5_o),
    .ret10_o      (ret10_o),
    .ret15_o      (ret15_o)
  );

  // Output bit order used throughout: {drop, ret5, ret10, ret15}.
  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic nn, input logic dd, input logic vv, input logic rr,
                      output logic [3:0] o);
    nickel_i = nn; dime_i = dd; vend_req_i = vv; refund_req_i = rr;
    @(posedge clk);
    @(negedge clk);
    o = {drop_o, ret5_o, ret10_o, ret15_o};
    nickel_i = 1'b0; dime_i = 1'b0; vend_req_i = 1'b0; refund_req_i = 1'b0;
  endtask

  function automatic logic [3:0] refund_pat(input int c);
    case (c)
      5:       return 4'b0100;
      10:      return 4'b0010;
      15:      return 4'b0001;
      20:      return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic set_credit(input int c);
    logic [3:0] o;
    step(0, 0, 0, 1, o);
    if (c >= 10) step(0, 1, 0, 0, o);
    if (c == 20) step(0, 1, 0, 0, o);
    if (c % 10 == 5) step(1, 0, 0, 0, o);
  endtask

  initial begin
    logic [3:0] o;
    logic [3:0] exp;
    int nc;
    string tag;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {drop_o, ret5_o, ret10_o, ret15_o}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 1, o);
    chk("R1 credit zero after reset", o, 4'b0000);

    for (int ci = 0; ci <= 4; ci++) begin
      for (int combo = 0; combo < 16; combo++) begin
        int c;
        logic nn, dd, vv, rr;
        c = ci * 5;
        {rr, vv, dd, nn} = 4'(combo);
        // Expected behaviour, by priority.
        if (rr) begin
          exp = refund_pat(c); nc = 0;
          tag = (c == 0) ? "R8 refund at zero" : "R7 refund";
        end else if (vv) begin
          if (c >= 15) begin
            exp = {1'b1, c == 20, 2'b00}; nc = 0; tag = "R5 item drop";
          end else begin
            exp = 4'b0000; nc = c; tag = "R6 short item request";
          end
        end else if (dd) begin
          if (c >= 15) begin exp = 4'b0010; nc = c; tag = "R4 dime returned"; end
          else begin exp = 4'b0000; nc = c + 10; tag = "R3 dime adds"; end
        end else if (nn) begin
          if (c >= 15) begin exp = 4'b0100; nc = c; tag = "R4 nickel returned"; end
          else begin exp = 4'b0000; nc = c + 5; tag = "R2 nickel adds"; end
        end else begin
          exp = 4'b0000; nc = c; tag = "R10 idle";
        end
        if ($countones(combo) > 1) tag = {"R9 priority / ", tag};

        set_credit(c);
        step(nn, dd, vv, rr, o);
        chk($sformatf("%s c=%0d in=%b", tag, c, combo[3:0]), o, exp);
        step(0, 0, 0, 0, o);
        chk("R10 pulse lasts one cycle", o, 4'b0000);
        step(0, 0, 0, 1, o);
        chk($sformatf("R7 credit readback after %s c=%0d in=%b", tag, c, combo[3:0]),
            o, refund_pat(nc));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule